// File: doc/BRIEF.md
# Double-Buffered Serial Byte Datapath

This block is the byte layer of a single-wire bus master. On the send side, the host drops a byte into a holding buffer. The byte then moves into a shift register, which hands bits to the slot generator one at a time, least significant bit first. On the receive side, bits reported by the slot generator are gathered into a shift register. Each completed byte is passed to a receive buffer for the host to collect.

Both directions share a single data address. A write to it fills the transmit holding buffer, and a read from it returns the receive buffer. Five status bits describe the state of the datapath:

- transmit holding empty
- transmit shifter empty
- receive shifter busy
- receive holding full
- a sticky overrun

Each of the first four status bits has its own interrupt enable. The interrupt line is high whenever an enabled status bit is set. Bus reset and the timing of each slot live outside this block. They reach it only as per-bit strobes.

Top module: `sbyte_dp`

## Requirements
- R1: The data register is at address 3'b001. A write there loads the transmit holding buffer, and a read there returns the receive buffer. A write to any other unused address has no effect on the transmit path. After reset the status reads 8'h03, and `irq` and `tx_bit_req` are low.
- R2: The transmit-holding-empty flag (status bit 0) clears on the clock edge that takes a data write.
- R3: A byte moves from the holding buffer into the shifter one cycle after the holding buffer fills and the shifter is empty. On that edge the transmit-shifter-empty flag (status bit 1) clears and status bit 0 sets.
- R4: While the shifter holds data, `tx_bit_req` is high and `tx_bit` carries the next bit, least significant first. Each `tx_bit_done` pulse advances one bit. After the eighth pulse, status bit 1 sets and a waiting byte loads on the next edge.
- R5: The receive-shifter-busy flag (status bit 2) sets on the first `rx_bit_stb` of a byte and clears on the eighth.
- R6: On the eighth received bit, the byte moves into the receive buffer and the receive-full flag (status bit 3) sets. The first received bit lands in bit 0. A read of the data register clears status bit 3.
- R7: If a byte completes while status bit 3 is set and no data read is happening, the new byte replaces the old one and the overrun flag (status bit 4) sets. The overrun flag stays set until a read of the status register at 3'b010.
- R8: The enable register at 3'b011 holds four bits, using the status bit order for bits 0 to 3, and reads back. `irq` is high exactly when some enabled flag among status bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read |
| tx_bit_req | output | 1 | Transmit shifter holds a bit to send |
| tx_bit | output | 1 | Bit value for the current transmit slot |
| tx_bit_done | input | 1 | Slot generator consumed the current bit |
| rx_bit_stb | input | 1 | A received bit is valid |
| rx_bit_val | input | 1 | Received bit value |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows up at the ports within a few cycles.

- **Transmit bit counter or shifter out of step.** `tx_bit` carries a wrong value at the very next slot, or `tx_bit_req` stays high one pulse too long or drops one pulse early.
- **Receive bit counter off by one.** Status bit 2 shows it after the first bit. The byte read from the data register comes out rotated.
- **Flag handling errors.** A missed reload, a lost overrun or a stuck receive-full flag changes the status word read one cycle after the event. It also changes `irq` in the same cycle, whenever that flag is enabled.

// File: rtl/sbyte_pkg.sv
package sbyte_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'b001;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'b011;

    localparam int NUM_IRQ_SRC = 4;

    typedef struct packed {
        logic ovr;
        logic rbf;
        logic rsrf;
        logic temt;
        logic tbe;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_IEN
    } sel_e;

    function automatic sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            ADDR_DATA: return SEL_DATA;
            ADDR_STAT: return SEL_STAT;
            ADDR_IEN:  return SEL_IEN;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [NUM_IRQ_SRC-1:0] irq_sources(stat_t s);
        return {s.rbf, s.rsrf, s.temt, s.tbe};
    endfunction

endpackage

// File: rtl/sbyte_tx.sv
module sbyte_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wdata,
    input  logic         bit_done,
    output logic         bit_req,
    output logic         bit_out,
    output logic         tbe,
    output logic         temt
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [W-1:0]     hold_q;
    logic [W-1:0]     shift_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
            left_q  <= '0;
            tbe     <= 1'b1;
            temt    <= 1'b1;
        end else begin
            if (temt && !tbe) begin
                shift_q <= hold_q;
                left_q  <= CNT_FULL;
                temt    <= 1'b0;
                tbe     <= 1'b1;
            end else if (!temt && bit_done) begin
                shift_q <= shift_q >> 1;
                left_q  <= left_q - CNT_ONE;
                if (left_q == CNT_ONE) temt <= 1'b1;
            end
            if (wr_stb) begin
                hold_q <= wdata;
                tbe    <= 1'b0;
            end
        end
    end

    assign bit_req = !temt;
    assign bit_out = shift_q[0];

    AST_TBE_CLR_ON_WR: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !tbe);                                                    // R2
    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (temt && !tbe && !wr_stb) |=> (!temt && tbe));                       // R3
    AST_LAST_BIT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (!temt && bit_done && left_q == CNT_ONE) |=> temt);                  // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (temt && tbe && !wr_stb) |=> (temt && $stable(shift_q)));            // R4
endmodule

// File: rtl/sbyte_rx.sv
module sbyte_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_stb,
    input  logic         bit_val,
    input  logic         rd_data_stb,
    input  logic         rd_stat_stb,
    output logic [W-1:0] rbuf,
    output logic         rsrf,
    output logic         rbf,
    output logic         ovr
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [W-1:0]     shift_q;
    logic [CNT_W-1:0] got_q;
    logic             complete;
    logic [W-1:0]     next_shift;

    assign complete   = bit_stb && (got_q == CNT_LAST);
    assign next_shift = {bit_val, shift_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            got_q   <= '0;
            rbuf    <= '0;
            rsrf    <= 1'b0;
            rbf     <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (bit_stb) begin
                shift_q <= next_shift;
                if (complete) begin
                    got_q <= '0;
                    rsrf  <= 1'b0;
                    rbuf  <= next_shift;
                end else begin
                    got_q <= got_q + CNT_ONE;
                    rsrf  <= 1'b1;
                end
            end
            if (complete)         rbf <= 1'b1;
            else if (rd_data_stb) rbf <= 1'b0;
            if (complete && rbf && !rd_data_stb) ovr <= 1'b1;
            else if (rd_stat_stb)                ovr <= 1'b0;
        end
    end

    AST_RSRF_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !rsrf && !complete) |=> rsrf);                           // R5
    AST_RBF_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        complete |=> (rbf && !rsrf));                                        // R6
    AST_RBF_CLR_ON_RD: assert property (@(posedge clk) disable iff (rst)
        (rd_data_stb && !complete) |=> !rbf);                                // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && !rd_stat_stb) |=> ovr);                                      // R7
endmodule

// File: rtl/sbyte_regs.sv
module sbyte_regs
    import sbyte_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [W-1:0]      wdata,
    input  stat_t             stat,
    input  logic [W-1:0]      rbuf,
    output logic [W-1:0]      rdata,
    output logic              wr_data_stb,
    output logic              rd_data_stb,
    output logic              rd_stat_stb,
    output logic              irq
);
    sel_e                   sel;
    logic [NUM_IRQ_SRC-1:0] ien_q;

    assign sel         = decode_addr(addr);
    assign wr_data_stb = wr && (sel == SEL_DATA);
    assign rd_data_stb = rd && (sel == SEL_DATA);
    assign rd_stat_stb = rd && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst)                      ien_q <= '0;
        else if (wr && sel == SEL_IEN) ien_q <= wdata[NUM_IRQ_SRC-1:0];
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DATA: rdata = rbuf;
            SEL_STAT: rdata = W'(stat);
            SEL_IEN:  rdata = W'(ien_q);
            default:  rdata = '0;
        endcase
    end

    assign irq = |(ien_q & irq_sources(stat));

    AST_IEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_IEN) |=> (ien_q == $past(wdata[NUM_IRQ_SRC-1:0]))); // R8
endmodule

// File: rtl/sbyte_dp.sv
module sbyte_dp
    import sbyte_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              tx_bit_req,
    output logic              tx_bit,
    input  logic              tx_bit_done,
    input  logic              rx_bit_stb,
    input  logic              rx_bit_val,
    output logic              irq
);
    stat_t        stat;
    logic [W-1:0] rbuf;
    logic         wr_data_stb;
    logic         rd_data_stb;
    logic         rd_stat_stb;

    sbyte_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_data_stb),
        .wdata    (reg_wdata),
        .bit_done (tx_bit_done),
        .bit_req  (tx_bit_req),
        .bit_out  (tx_bit),
        .tbe      (stat.tbe),
        .temt     (stat.temt)
    );

    sbyte_rx #(.W(W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .bit_stb     (rx_bit_stb),
        .bit_val     (rx_bit_val),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .rbuf        (rbuf),
        .rsrf        (stat.rsrf),
        .rbf         (stat.rbf),
        .ovr         (stat.ovr)
    );

    sbyte_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr        (reg_addr),
        .wr          (reg_wr),
        .rd          (reg_rd),
        .wdata       (reg_wdata),
        .stat        (stat),
        .rbuf        (rbuf),
        .rdata       (reg_rdata),
        .wr_data_stb (wr_data_stb),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .irq         (irq)
    );
endmodule

// File: tb/sbyte_dp_test.sv
module sbyte_dp_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_DATA = 3'b001;
    localparam logic [2:0] A_STAT = 3'b010;
    localparam logic [2:0] A_IEN  = 3'b011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_bit_req;
    logic       tx_bit;
    logic       tx_bit_done = 1'b0;
    logic       rx_bit_stb = 1'b0;
    logic       rx_bit_val = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbyte_dp uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_bit_req(tx_bit_req), .tx_bit(tx_bit), .tx_bit_done(tx_bit_done),
        .rx_bit_stb(rx_bit_stb), .rx_bit_val(rx_bit_val), .irq(irq)
    );

    function automatic logic [7:0] stat_word(bit ovr, bit rbf, bit rsrf,
                                             bit temt, bit tbe);
        return {3'b000, ovr, rbf, rsrf, temt, tbe};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tx_expect(logic [7:0] b, int gap);
        for (int i = 0; i < 8; i++) begin
            int t = 0;
            while (!tx_bit_req && t < 50) begin @(negedge clk); t++; end
            chk("R4 tx_bit_req", {7'b0, tx_bit_req}, 8'h01);
            chk("R4 tx_bit", {7'b0, tx_bit}, {7'b0, b[i]});
            tx_bit_done = 1'b1;
            @(negedge clk);
            tx_bit_done = 1'b0;
            if (gap > 0) idle($urandom_range(gap, 0));
        end
    endtask

    task automatic rx_bit(logic v);
        rx_bit_val = v; rx_bit_stb = 1'b1;
        @(negedge clk);
        rx_bit_stb = 1'b0;
    endtask

    task automatic rx_byte(logic [7:0] b, int gap);
        for (int i = 0; i < 8; i++) begin
            rx_bit(b[i]);
            if (gap > 0) idle($urandom_range(gap, 0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] b;
        logic [7:0] b2;
        void'($urandom(32'd20517));
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        chk("R1 tx_bit_req after reset", {7'b0, tx_bit_req}, 8'h00);
        rd(A_STAT, d); chk("R1 status after reset", d, stat_word(0,0,0,1,1));

        // R1 write to an unused address leaves transmit path alone
        wr(3'b000, 8'hA5);
        rd(A_STAT, d); chk("R1 unused address write", d, stat_word(0,0,0,1,1));
        chk("R1 no tx after unused write", {7'b0, tx_bit_req}, 8'h00);

        // R2/R3 directed: flag sequence around the load
        wr(A_DATA, 8'h96);
        rd(A_STAT, d); chk("R2 tbe clears on write", d, stat_word(0,0,0,1,0));
        rd(A_STAT, d); chk("R3 load moves flags", d, stat_word(0,0,0,0,1));
        wr(A_DATA, 8'h3C);
        rd(A_STAT, d); chk("R2 second byte waits", d, stat_word(0,0,0,0,0));
        tx_expect(8'h96, 0);
        // last done edge set temt; holding byte loads on the next edge
        rd(A_STAT, d); chk("R4 reload after last bit", d, stat_word(0,0,0,1,0));
        tx_expect(8'h3C, 2);
        idle(1);
        rd(A_STAT, d); chk("R4 idle after drain", d, stat_word(0,0,0,1,1));

        // R4 random transmit bytes with bubbles
        for (int n = 0; n < 20; n++) begin
            b = 8'($urandom);
            wr(A_DATA, b);
            tx_expect(b, 3);
        end
        idle(2);

        // R5 receive shifter busy from the first bit
        rx_bit(1'b1);
        rd(A_STAT, d); chk("R5 rsrf on first bit", d, stat_word(0,0,1,1,1));
        for (int i = 1; i < 8; i++) rx_bit(i[0]);
        rd(A_STAT, d); chk("R5 R6 flags after byte", d, stat_word(0,1,0,1,1));
        rd(A_DATA, d); chk("R6 lsb first data", d, 8'hAB);
        rd(A_STAT, d); chk("R6 rbf clears on read", d, stat_word(0,0,0,1,1));

        // R6 random receive bytes
        for (int n = 0; n < 20; n++) begin
            b = 8'($urandom);
            rx_byte(b, 2);
            rd(A_DATA, d); chk("R6 random rx byte", d, b);
        end

        // R7 overrun
        b = 8'h5A; b2 = 8'hC3;
        rx_byte(b, 0);
        rx_byte(b2, 1);
        rd(A_STAT, d); chk("R7 overrun set", d, stat_word(1,1,0,1,1));
        rd(A_STAT, d); chk("R7 overrun clears on status read", d, stat_word(0,1,0,1,1));
        rd(A_DATA, d); chk("R7 newest byte kept", d, b2);
        rx_byte(8'h11, 0);
        rd(A_DATA, d); chk("R7 no overrun after read", d, 8'h11);
        rd(A_STAT, d); chk("R7 status clean", d, stat_word(0,0,0,1,1));

        // R8 interrupt enables
        wr(A_IEN, 8'h01);
        chk("R8 irq from tbe", {7'b0, irq}, 8'h01);
        rd(A_IEN, d); chk("R8 enable readback", d, 8'h01);
        wr(A_IEN, 8'h08);
        chk("R8 rbf masked source idle", {7'b0, irq}, 8'h00);
        rx_byte(8'h77, 0);
        chk("R8 irq from rbf", {7'b0, irq}, 8'h01);
        rd(A_DATA, d);
        chk("R8 irq drops after read", {7'b0, irq}, 8'h00);
        wr(A_IEN, 8'h04);
        rx_bit(1'b0);
        chk("R8 irq from rsrf", {7'b0, irq}, 8'h01);
        for (int i = 1; i < 8; i++) rx_bit(1'b0);
        chk("R8 rsrf irq clears", {7'b0, irq}, 8'h00);
        rd(A_DATA, d);
        wr(A_IEN, 8'h02);
        wr(A_DATA, 8'hF0);
        chk("R8 temt still set before load", {7'b0, irq}, 8'h01);
        @(negedge clk);
        chk("R8 temt irq drops on load", {7'b0, irq}, 8'h00);
        tx_expect(8'hF0, 0);
        wr(A_IEN, 8'h00);
        chk("R8 all disabled", {7'b0, irq}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule